// File: doc/BRIEF.md
# Byte-Wide Task File Shadow with 48-bit LBA Pairing

This block keeps a shadow copy of the byte-wide ATA task file for two channels, primary and secondary. Software can load a 48-bit LBA, a 16-bit sector count and 16-bit features through 8-bit I/O ports. Each of these five registers is a two-deep queue. A write pushes the new byte in and moves the byte it replaces into an older slot. The high-order bit of the device control byte chooses which of the two slots a read returns.

A write to the command offset builds a 20-byte host-to-device register FIS from the channel's current state. The older byte of each pair goes into the expanded fields and the newer byte goes into the base fields. The FIS is presented with a one-cycle valid strobe. Reads complete one cycle after the request. The design uses one synchronous active-high reset.

Top module: `tf_shadow`

## Requirements
- R1: After reset every queue slot, device byte and control byte is 0x00, `rd_valid` and `fis_valid` are low, and `rd_data` is 0x00.
- R2: A write to command-block offset 1 (features), 2 (sector count), 3 (LBA low), 4 (LBA mid) or 5 (LBA high) stores the byte as the newest entry and moves the previous newest entry to the oldest slot.
- R3: A read is answered one cycle later with `rd_valid` high for that one cycle. When control bit 7 is 0, a queued register returns its newest entry.
- R4: When control bit 7 is 1, a read of a queued register returns its oldest entry.
- R5: The primary command block decodes at 0x1F0 to 0x1F7 and primary control at 0x3F6. The secondary command block decodes at 0x170 to 0x177 and secondary control at 0x376. The two channels' state is fully independent.
- R6: A control write with bit 2 clear leaves every queue entry intact. A control write with bit 2 set clears both slots of all five queues of that channel only.
- R7: A write to command-block offset 7 raises `fis_valid` on the next cycle for one cycle. `fis_chan` is 0 for primary and 1 for secondary.
- R8: FIS byte k sits at `fis_data[8k+7:8k]` with this content:
  - byte 0 is 0x27 and byte 1 is 0x80;
  - byte 2 is the command, byte 3 is features newest, and bytes 4 to 6 are LBA low, mid and high newest;
  - byte 7 is the device byte;
  - bytes 8 to 10 are LBA low, mid and high oldest, and byte 11 is features oldest;
  - byte 12 is count newest, byte 13 is count oldest, and byte 15 is the control byte;
  - bytes 14 and 16 to 19 are zero.
- R9: Offset 6 holds a single device byte that reads back regardless of control bit 7. A read of a control address returns the last control byte written. Reads of offsets 0 and 7 and of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | I/O address |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| fis_valid | output | 1 | One-cycle FIS strobe |
| fis_chan | output | 1 | Channel of the FIS (0 primary, 1 secondary) |
| fis_data | output | 160 | Assembled register FIS, byte k at bits 8k+7:8k |

## Verification
The hardest state to reach is one where both slots of every queue hold distinct, known bytes on both channels at once. Only in that state is a wrong pairing, a wrong FIS byte position or a leak between channels visible. The bench writes value pairs derived from the channel and register index into every queue, then flips control bit 7 to read both slots. It then issues a command and compares all 20 FIS bytes against a model. Soft reset is applied to one channel only, and the other channel's readback is checked.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int TF_DW     = 8;
  localparam int NUM_CH    = 2;
  localparam int NUM_Q     = 5;
  localparam int FIS_BYTES = 20;
  localparam int FIS_W     = FIS_BYTES * TF_DW;

  // command-block offsets (ATA ordering, decoded by the device side)
  localparam logic [2:0] OFF_FEAT = 3'd1;
  localparam logic [2:0] OFF_DEV  = 3'd6;
  localparam logic [2:0] OFF_CMD  = 3'd7;

  // queue index = offset - 1
  localparam int Q_FEAT = 0;
  localparam int Q_CNT  = 1;
  localparam int Q_LO   = 2;
  localparam int Q_MID  = 3;
  localparam int Q_HI   = 4;

  localparam int CTL_HOB_BIT  = 7;
  localparam int CTL_SRST_BIT = 2;

  typedef logic [NUM_Q-1:0][TF_DW-1:0] qbytes_t;
endpackage

// File: rtl/tf_pair.sv
module tf_pair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] newest,
  output logic [DW-1:0] oldest
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      newest <= '0;
      oldest <= '0;
    end else if (push) begin
      oldest <= newest;
      newest <= din;
    end
  end
endmodule

// File: rtl/tf_decode.sv
module tf_decode #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] PRI_CMD = 16'h01F0,
  parameter logic [15:0] PRI_CTL = 16'h03F6,
  parameter logic [15:0] SEC_CMD = 16'h0170,
  parameter logic [15:0] SEC_CTL = 16'h0376
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        cmd_hit,
  output logic [1:0]        ctl_hit,
  output logic [2:0]        off
);
  logic [ADDR_W-1:0] cmd_base [2];
  logic [ADDR_W-1:0] ctl_addr [2];

  assign cmd_base[0] = ADDR_W'(PRI_CMD);
  assign cmd_base[1] = ADDR_W'(SEC_CMD);
  assign ctl_addr[0] = ADDR_W'(PRI_CTL);
  assign ctl_addr[1] = ADDR_W'(SEC_CTL);
  assign off = addr[2:0];

  for (genvar c = 0; c < 2; c++) begin : g_hit
    assign cmd_hit[c] = (addr[ADDR_W-1:3] == cmd_base[c][ADDR_W-1:3]);
    assign ctl_hit[c] = (addr == ctl_addr[c]);
  end
endmodule

// File: rtl/tf_fis_pack.sv
module tf_fis_pack
  import tf_pkg::*;
(
  input  logic [TF_DW-1:0] command,
  input  logic [TF_DW-1:0] device,
  input  logic [TF_DW-1:0] control,
  input  qbytes_t          cur,
  input  qbytes_t          prev,
  output logic [FIS_W-1:0] fis
);
  logic [FIS_BYTES-1:0][TF_DW-1:0] b;

  always_comb begin
    b      = '0;
    b[0]   = 8'h27;
    b[1]   = 8'h80;
    b[2]   = command;
    b[3]   = cur[Q_FEAT];
    b[4]   = cur[Q_LO];
    b[5]   = cur[Q_MID];
    b[6]   = cur[Q_HI];
    b[7]   = device;
    b[8]   = prev[Q_LO];
    b[9]   = prev[Q_MID];
    b[10]  = prev[Q_HI];
    b[11]  = prev[Q_FEAT];
    b[12]  = cur[Q_CNT];
    b[13]  = prev[Q_CNT];
    b[15]  = control;
  end

  assign fis = b;
endmodule

// File: rtl/tf_shadow.sv
module tf_shadow
  import tf_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] PRI_CMD = 16'h01F0,
  parameter logic [15:0] PRI_CTL = 16'h03F6,
  parameter logic [15:0] SEC_CMD = 16'h0170,
  parameter logic [15:0] SEC_CTL = 16'h0376
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [TF_DW-1:0]     wdata,
  output logic [TF_DW-1:0]     rd_data,
  output logic                 rd_valid,
  output logic                 fis_valid,
  output logic                 fis_chan,
  output logic [FIS_W-1:0]     fis_data
);
  logic [1:0] cmd_hit, ctl_hit;
  logic [2:0] off;

  tf_decode #(
    .ADDR_W(ADDR_W), .PRI_CMD(PRI_CMD), .PRI_CTL(PRI_CTL),
    .SEC_CMD(SEC_CMD), .SEC_CTL(SEC_CTL)
  ) dec_i (
    .addr(addr), .cmd_hit(cmd_hit), .ctl_hit(ctl_hit), .off(off)
  );

  qbytes_t          q_new [NUM_CH];
  qbytes_t          q_old [NUM_CH];
  logic [TF_DW-1:0] dev_r [NUM_CH];
  logic [TF_DW-1:0] ctl_r [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic soft_clr;
    assign soft_clr = wr_en && ctl_hit[c] && wdata[CTL_SRST_BIT];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic push;
      assign push = wr_en && cmd_hit[c] && (off == 3'(q + 1));
      tf_pair #(.DW(TF_DW)) pair_i (
        .clk(clk), .rst(rst), .clr(soft_clr), .push(push), .din(wdata),
        .newest(q_new[c][q]), .oldest(q_old[c][q])
      );
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dev_r[c] <= '0;
        ctl_r[c] <= '0;
      end else if (wr_en) begin
        if (cmd_hit[c] && off == OFF_DEV) dev_r[c] <= wdata;
        if (ctl_hit[c])                   ctl_r[c] <= wdata;
      end
    end
  end

  // read selection
  logic [TF_DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cmd_hit[c]) begin
        if (off >= OFF_FEAT && off < OFF_DEV) begin
          rd_next = ctl_r[c][CTL_HOB_BIT] ? q_old[c][int'(off) - 1]
                                          : q_new[c][int'(off) - 1];
        end else if (off == OFF_DEV) begin
          rd_next = dev_r[c];
        end
      end
      if (ctl_hit[c]) rd_next = ctl_r[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_next : '0;
    end
  end

  // FIS assembly on command write
  logic             cmd_wr;
  logic             cmd_ch;
  logic [FIS_W-1:0] fis_next;

  assign cmd_wr = wr_en && (|cmd_hit) && (off == OFF_CMD);
  assign cmd_ch = cmd_hit[1];

  tf_fis_pack pack_i (
    .command(wdata),
    .device (dev_r[cmd_ch]),
    .control(ctl_r[cmd_ch]),
    .cur    (q_new[cmd_ch]),
    .prev   (q_old[cmd_ch]),
    .fis    (fis_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fis_valid <= 1'b0;
      fis_chan  <= 1'b0;
      fis_data  <= '0;
    end else begin
      fis_valid <= cmd_wr;
      if (cmd_wr) begin
        fis_chan <= cmd_ch;
        fis_data <= fis_next;
      end
    end
  end
endmodule

// File: rtl/tf_shadow_chk.sv
module tf_shadow_chk #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] PRI_CMD = 16'h01F0,
  parameter logic [15:0] PRI_CTL = 16'h03F6,
  parameter logic [15:0] SEC_CMD = 16'h0170
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              fis_valid,
  input logic              fis_chan,
  input logic [159:0]      fis_data
);
  logic pri_cmd_wr, sec_cmd_wr;
  assign pri_cmd_wr = wr_en && addr == ADDR_W'(PRI_CMD + 16'd7);
  assign sec_cmd_wr = wr_en && addr == ADDR_W'(SEC_CMD + 16'd7);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !fis_valid && rd_data == 8'h00));

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid == $past(rd_en));

  // R7
  fis_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    fis_valid == $past(pri_cmd_wr || sec_cmd_wr));

  // R7
  fis_channel_chk: assert property (@(posedge clk) disable iff (rst)
    fis_valid |-> (fis_chan == $past(sec_cmd_wr)));

  // R8
  fis_header_chk: assert property (@(posedge clk) disable iff (rst)
    fis_valid |-> (fis_data[7:0] == 8'h27 && fis_data[15:8] == 8'h80
                   && fis_data[159:128] == 32'h0));

  // R6
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && addr == ADDR_W'(PRI_CTL) && wdata[2], 2)
     && $past(rd_en && !wr_en && addr == ADDR_W'(PRI_CMD + 16'd1)))
    |-> rd_data == 8'h00);
endmodule

bind tf_shadow tf_shadow_chk #(
  .ADDR_W(ADDR_W), .PRI_CMD(PRI_CMD), .PRI_CTL(PRI_CTL), .SEC_CMD(SEC_CMD)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
  .fis_valid(fis_valid), .fis_chan(fis_chan), .fis_data(fis_data)
);

// File: tb/tf_shadow_tb_top.sv
module tf_shadow_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, rd_en;
  logic [15:0]  addr;
  logic [7:0]   wdata;
  logic [7:0]   rd_data;
  logic         rd_valid;
  logic         fis_valid;
  logic         fis_chan;
  logic [159:0] fis_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tf_shadow dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .fis_valid(fis_valid), .fis_chan(fis_chan), .fis_data(fis_data)
  );

  // model
  logic [7:0] m_new [2][8];
  logic [7:0] m_old [2][8];
  logic [7:0] m_dev [2];
  logic [7:0] m_ctl [2];

  function automatic logic [15:0] cmd_base(int ch);
    return ch == 0 ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [15:0] ctl_addr(int ch);
    return ch == 0 ? 16'h03F6 : 16'h0376;
  endfunction

  function automatic logic [7:0] exp_tf(int ch, int off);
    if (off >= 1 && off <= 5) return m_ctl[ch][7] ? m_old[ch][off] : m_new[ch][off];
    if (off == 6) return m_dev[ch];
    return 8'h00;
  endfunction

  function automatic logic [159:0] exp_fis(int ch, logic [7:0] cmd);
    logic [159:0] f = '0;
    f[7:0]     = 8'h27;
    f[15:8]    = 8'h80;
    f[23:16]   = cmd;
    f[31:24]   = m_new[ch][1];
    f[39:32]   = m_new[ch][3];
    f[47:40]   = m_new[ch][4];
    f[55:48]   = m_new[ch][5];
    f[63:56]   = m_dev[ch];
    f[71:64]   = m_old[ch][3];
    f[79:72]   = m_old[ch][4];
    f[87:80]   = m_old[ch][5];
    f[95:88]   = m_old[ch][1];
    f[103:96]  = m_new[ch][2];
    f[111:104] = m_old[ch][2];
    f[127:120] = m_ctl[ch];
    return f;
  endfunction

  task automatic chk(string tag, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_tf(int ch, int off, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = cmd_base(ch) + 16'(off); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (off >= 1 && off <= 5) begin
      m_old[ch][off] = m_new[ch][off];
      m_new[ch][off] = d;
    end else if (off == 6) begin
      m_dev[ch] = d;
    end
  endtask

  task automatic wr_ctl(int ch, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ctl_addr(ch); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_ctl[ch] = d;
    if (d[2]) begin
      for (int o = 1; o <= 5; o++) begin
        m_new[ch][o] = 8'h00;
        m_old[ch][o] = 8'h00;
      end
    end
  endtask

  task automatic rd_chk(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rd_valid"}, 160'(rd_valid), 160'(1'b1));
    chk(tag, 160'(rd_data), 160'(exp));
  endtask

  task automatic rd_all(int ch, string tag);
    for (int o = 0; o < 8; o++)
      rd_chk(cmd_base(ch) + 16'(o), exp_tf(ch, o), tag);
  endtask

  task automatic cmd_chk(int ch, logic [7:0] cmd);
    logic [159:0] e;
    e = exp_fis(ch, cmd);
    @(negedge clk);
    wr_en = 1'b1; addr = cmd_base(ch) + 16'd7; wdata = cmd;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 fis_valid high", 160'(fis_valid), 160'(1'b1));
    chk("R7 fis_chan", 160'(fis_chan), 160'(ch));
    chk("R8 fis_data", fis_data, e);
    @(negedge clk);
    chk("R7 fis_valid one cycle", 160'(fis_valid), 160'(1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      for (int o = 0; o < 8; o++) begin
        m_new[c][o] = 8'h00;
        m_old[c][o] = 8'h00;
      end
      m_dev[c] = 8'h00;
      m_ctl[c] = 8'h00;
    end
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rd_valid", 160'(rd_valid), 160'(1'b0));
    chk("R1 fis_valid", 160'(fis_valid), 160'(1'b0));
    chk("R1 rd_data", 160'(rd_data), 160'(8'h00));
    for (int c = 0; c < 2; c++) begin
      rd_all(c, "R1 newest after reset");
      wr_ctl(c, 8'h80);
      rd_all(c, "R1 oldest after reset");
      wr_ctl(c, 8'h00);
    end

    // R2 R3 R4 sweep over channel, register, value pair
    for (int c = 0; c < 2; c++) begin
      for (int o = 1; o <= 5; o++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] a, b;
          a = 8'(k * 37 + o * 11 + c * 5 + 1);
          b = 8'(~a + 8'(k * 3));
          wr_tf(c, o, a);
          wr_tf(c, o, b);
          wr_ctl(c, 8'h00);
          rd_chk(cmd_base(c) + 16'(o), b, "R3 newest entry");
          wr_ctl(c, 8'h80);
          rd_chk(cmd_base(c) + 16'(o), a, "R4 oldest entry");
          rd_chk(cmd_base(c) + 16'(o), exp_tf(c, o), "R2 shift pair");
        end
      end
    end

    // R5 independent channels with distinct contents
    for (int o = 1; o <= 5; o++) begin
      wr_tf(0, o, 8'(8'h10 + o));
      wr_tf(0, o, 8'(8'h20 + o));
      wr_tf(1, o, 8'(8'hA0 + o));
      wr_tf(1, o, 8'(8'hB0 + o));
    end
    wr_ctl(0, 8'h00);
    wr_ctl(1, 8'h80);
    rd_all(0, "R5 primary view");
    rd_all(1, "R5 secondary view");

    // R9 device byte, control readback, zero offsets
    wr_tf(0, 6, 8'hE5);
    wr_tf(1, 6, 8'h4A);
    rd_chk(16'h01F6, 8'hE5, "R9 device hob0");
    rd_chk(16'h0176, 8'h4A, "R9 device hob1");
    rd_chk(16'h03F6, m_ctl[0], "R9 control readback pri");
    rd_chk(16'h0376, m_ctl[1], "R9 control readback sec");
    rd_chk(16'h01F0, 8'h00, "R9 data offset zero");
    rd_chk(16'h01F7, 8'h00, "R9 command offset zero");
    rd_chk(16'h1234, 8'h00, "R9 unmapped zero");

    // R8 FIS assembly on both channels
    cmd_chk(0, 8'h25);
    cmd_chk(1, 8'h35);

    // R6 control write without soft reset keeps entries
    wr_ctl(0, 8'h02);
    wr_ctl(0, 8'h80);
    rd_all(0, "R6 no clear hob1");
    wr_ctl(0, 8'h00);
    rd_all(0, "R6 no clear hob0");

    // R6 soft reset on primary only
    wr_ctl(0, 8'h04);
    rd_all(0, "R6 primary cleared");
    wr_ctl(0, 8'h84);
    rd_all(0, "R6 primary oldest cleared");
    rd_all(1, "R6 secondary untouched");
    wr_ctl(0, 8'h00);
    cmd_chk(0, 8'hEC);
    cmd_chk(1, 8'hC8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule